// File: doc/BRIEF.md
# Strided Vector Load Engine over Interleaved Banks

This block runs one strided vector load at a time against a word-interleaved memory. The memory is split into eight banks. Each word belongs to the bank given by its address modulo eight. A load is described by a starting word address, a stride and an element count. Element i is fetched from the word at `base + i*stride`, with the address wrapping modulo 256.

The engine sends at most one element request per clock. When the bank that the next element needs has not finished its previous access, the engine waits. Each request returns its word after a fixed latency, and the words leave on an output stream in element order. When the last element appears, a one-cycle done strobe reports how many cycles the whole load took. The cycle count therefore shows directly how the stride interacts with the bank count. A unit stride streams at one word per clock. A stride that is a multiple of eight hits the same bank every time and is paced by the bank recovery time.

The bank contents are a fixed computed pattern. This lets every returned word be checked for both address and ordering.

Top module: `strided_load_engine`

## Requirements
- R1: A pulse on `start_i` while `busy_o` is low captures `base_i`, `stride_i` and `len_m1_i`, where the element count is `len_m1_i + 1` (1 to 64). `busy_o` is high from the next cycle until the cycle after the done strobe.
- R2: Element i carries the word stored at address `(base + i*stride) mod 256`. The word at address a holds `{a ^ 8'h5A, a}`, with the upper byte XORed and the lower byte equal to a.
- R3: Element addresses map to bank `address mod 8`. After a bank accepts a request, it accepts no other request during the following 5 cycles, so two accesses to one bank are at least 6 cycles apart.
- R4: Requests leave in element order, at most one per cycle. Each request is sent in the first cycle in which its bank is free.
- R5: A word is delivered 12 cycles after its request. The first element of a load appears 13 cycles after the cycle in which `start_i` was taken.
- R6: Delivered elements carry `elem_valid_o` and an index `elem_idx_o` that starts at 0 and rises by one per element. Exactly the element count of words is delivered.
- R7: `done_o` is high in the cycle of the last element only. In that cycle, `done_cycles_o` equals the number of cycles from the first request cycle through the last delivery, both included. This is 76 for 64 elements at stride 1 and 391 for 64 elements at stride 32.
- R8: A stride of 0 is legal. Every element then reads the same word, and consecutive elements are delivered exactly 6 cycles apart.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The running load completes with its own parameters and timing.
- R10: Asserting `rst_n` low forces `busy_o`, `elem_valid_o` and `done_o` low at once and abandons any load in flight. After release, a new load runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for a new load |
| base_i | input | 8 | Word address of element 0 |
| stride_i | input | 8 | Address step between elements (unsigned, wraps) |
| len_m1_i | input | 6 | Element count minus one |
| busy_o | output | 1 | A load is in progress |
| elem_valid_o | output | 1 | An element is on the output this cycle |
| elem_idx_o | output | 6 | Index of the element on the output |
| elem_data_o | output | 16 | Word of the element on the output |
| done_o | output | 1 | Last element of the load is on the output |
| done_cycles_o | output | 16 | Total load cycles, meaningful when `done_o` is high |

## Verification
The bench counts cycles from the negative edge at which it raises `start_i`. It expects element 0 exactly 13 cycles later and the final element, together with the done strobe, exactly as many cycles after start as the expected total. These totals come from the bank-conflict pattern of each stride and were worked out by hand. For a zero stride, successive elements must be exactly 6 cycles apart. `busy_o` must be high one cycle after start and low one cycle after done. All outputs are sampled at the falling edge, half a period clear of the edge that updates them. Reset effects are sampled 1 ns after the reset is driven, because they do not wait for a clock.

// File: rtl/strload_pkg.sv
package strload_pkg;
  localparam int unsigned DEF_BANKS    = 8;
  localparam int unsigned DEF_BUSY     = 6;
  localparam int unsigned DEF_LATENCY  = 12;
  localparam int unsigned DEF_ADDR_W   = 8;
  localparam int unsigned DEF_MAX_LEN  = 64;
  localparam int unsigned DEF_CNT_W    = 16;
  localparam int unsigned DEF_BUSY_W   = 6;
  localparam logic [7:0]  FILL_KEY     = 8'h5A;
endpackage

// File: rtl/slb_rst_sync.sv
module slb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/slb_bank_timer.sv
module slb_bank_timer #(
  parameter int unsigned NB     = 8,
  parameter int unsigned BUSY   = 6,
  parameter int unsigned BUSY_W = 6,
  localparam int unsigned BW    = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [BW-1:0] fire_bank,
  output logic [NB-1:0] idle
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [BUSY_W-1:0] cnt_q, cnt_d;
    logic              load_en;

    assign load_en = fire && (fire_bank == BW'(b));

    always_comb begin
      cnt_d = cnt_q;
      if (load_en)           cnt_d = BUSY_W'(BUSY - 1);
      else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign idle[b] = (cnt_q == '0);
  end
endmodule

// File: rtl/slb_bank_array.sv
module slb_bank_array #(
  parameter int unsigned NB     = 8,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned BW    = $clog2(NB),
  localparam int unsigned ROW_W = ADDR_W - BW,
  localparam int unsigned ROWS  = 1 << ROW_W,
  localparam int unsigned DW    = 2 * ADDR_W
) (
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data
);
  import strload_pkg::*;

  logic [DW-1:0] mem [NB][ROWS];
  logic [DW-1:0] bank_word [NB];

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      for (int r = 0; r < ROWS; r++) begin
        logic [ADDR_W-1:0] a;
        a = ADDR_W'(r * NB + b);
        mem[b][r] = {a ^ ADDR_W'(FILL_KEY), a};
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_rd
    assign bank_word[b] = mem[b][rd_addr[ADDR_W-1:BW]];
  end

  assign rd_data = bank_word[rd_addr[BW-1:0]];
endmodule

// File: rtl/slb_return_pipe.sv
module slb_return_pipe #(
  parameter int unsigned LAT = 12,
  parameter int unsigned W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_p,
  output logic         out_v,
  output logic [W-1:0] out_p
);
  logic         v_q [LAT];
  logic [W-1:0] p_q [LAT];

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    logic         v_in;
    logic [W-1:0] p_in;
    if (s == 0) begin : g_first
      assign v_in = in_v;
      assign p_in = in_p;
    end else begin : g_next
      assign v_in = v_q[s-1];
      assign p_in = p_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q[s] <= 1'b0;
      else        v_q[s] <= v_in;
    end

    always_ff @(posedge clk) begin
      if (v_in) p_q[s] <= p_in;
    end
  end

  assign out_v = v_q[LAT-1];
  assign out_p = p_q[LAT-1];
endmodule

// File: rtl/strided_load_engine.sv
module strided_load_engine #(
  parameter int unsigned NB      = strload_pkg::DEF_BANKS,
  parameter int unsigned BUSY    = strload_pkg::DEF_BUSY,
  parameter int unsigned LAT     = strload_pkg::DEF_LATENCY,
  parameter int unsigned ADDR_W  = strload_pkg::DEF_ADDR_W,
  parameter int unsigned MAX_LEN = strload_pkg::DEF_MAX_LEN,
  parameter int unsigned CNT_W   = strload_pkg::DEF_CNT_W,
  parameter int unsigned BUSY_W  = strload_pkg::DEF_BUSY_W,
  localparam int unsigned BW     = $clog2(NB),
  localparam int unsigned IDX_W  = $clog2(MAX_LEN),
  localparam int unsigned LEN_W  = IDX_W + 1,
  localparam int unsigned DW     = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [IDX_W-1:0]  len_m1_i,
  output logic              busy_o,
  output logic              elem_valid_o,
  output logic [IDX_W-1:0]  elem_idx_o,
  output logic [DW-1:0]     elem_data_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  done_cycles_o
);
  localparam int unsigned PW = 1 + IDX_W + DW;

  logic rst_sn;

  logic              run_q,    run_d;
  logic [LEN_W-1:0]  issued_q, issued_d;
  logic [LEN_W-1:0]  len_q,    len_d;
  logic [ADDR_W-1:0] addr_q,   addr_d;
  logic [ADDR_W-1:0] stride_q, stride_d;
  logic [CNT_W-1:0]  cnt_q,    cnt_d;

  logic              start_take;
  logic              issue_fire;
  logic [BW-1:0]     issue_bank;
  logic [NB-1:0]     bank_idle;
  logic [DW-1:0]     rd_word;
  logic              is_last;
  logic [PW-1:0]     req_p, ret_p;
  logic              ret_v, ret_last;
  logic [IDX_W-1:0]  ret_idx;
  logic [DW-1:0]     ret_data;

  slb_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign start_take = start_i && !run_q;
  assign issue_bank = addr_q[BW-1:0];
  assign issue_fire = run_q && (issued_q < len_q) && bank_idle[issue_bank];
  assign is_last    = (issued_q == (len_q - 1'b1));

  slb_bank_timer #(.NB(NB), .BUSY(BUSY), .BUSY_W(BUSY_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_sn),
    .fire      (issue_fire),
    .fire_bank (issue_bank),
    .idle      (bank_idle)
  );

  slb_bank_array #(.NB(NB), .ADDR_W(ADDR_W)) u_mem (
    .rd_addr (addr_q),
    .rd_data (rd_word)
  );

  assign req_p = {is_last, issued_q[IDX_W-1:0], rd_word};

  slb_return_pipe #(.LAT(LAT), .W(PW)) u_ret (
    .clk   (clk),
    .rst_n (rst_sn),
    .in_v  (issue_fire),
    .in_p  (req_p),
    .out_v (ret_v),
    .out_p (ret_p)
  );

  assign {ret_last, ret_idx, ret_data} = ret_p;

  always_comb begin
    run_d    = run_q;
    issued_d = issued_q;
    len_d    = len_q;
    addr_d   = addr_q;
    stride_d = stride_q;
    cnt_d    = cnt_q;
    if (start_take) begin
      run_d    = 1'b1;
      issued_d = '0;
      len_d    = {1'b0, len_m1_i} + 1'b1;
      addr_d   = base_i;
      stride_d = stride_i;
      cnt_d    = CNT_W'(1);
    end else if (run_q) begin
      cnt_d = cnt_q + 1'b1;
      if (issue_fire) begin
        issued_d = issued_q + 1'b1;
        addr_d   = addr_q + stride_q;
      end
      if (ret_v && ret_last) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      run_q    <= 1'b0;
      issued_q <= '0;
      len_q    <= '0;
      addr_q   <= '0;
      stride_q <= '0;
      cnt_q    <= '0;
    end else begin
      run_q    <= run_d;
      issued_q <= issued_d;
      len_q    <= len_d;
      addr_q   <= addr_d;
      stride_q <= stride_d;
      cnt_q    <= cnt_d;
    end
  end

  assign busy_o        = run_q;
  assign elem_valid_o  = ret_v;
  assign elem_idx_o    = ret_idx;
  assign elem_data_o   = ret_data;
  assign done_o        = ret_v && ret_last;
  assign done_cycles_o = cnt_q;
endmodule

// File: rtl/strided_load_engine_chk.sv
module strided_load_engine_chk #(
  parameter int unsigned NB      = 8,
  parameter int unsigned BUSY    = 6,
  parameter int unsigned MAX_LEN = 64,
  localparam int unsigned BW     = $clog2(NB),
  localparam int unsigned IDX_W  = $clog2(MAX_LEN),
  localparam int unsigned AGE_W  = $clog2(BUSY + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             elem_valid_o,
  input logic [IDX_W-1:0] elem_idx_o,
  input logic             done_o,
  input logic             issue_fire,
  input logic [BW-1:0]    issue_bank
);
  logic [AGE_W-1:0] age_q [NB];
  logic [IDX_W-1:0] exp_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) age_q[b] <= AGE_W'(BUSY);
      exp_idx_q <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (issue_fire && issue_bank == BW'(b)) age_q[b] <= AGE_W'(1);
        else if (age_q[b] < AGE_W'(BUSY))        age_q[b] <= age_q[b] + 1'b1;
      end
      if (start_i && !busy_o)  exp_idx_q <= '0;
      else if (elem_valid_o)   exp_idx_q <= exp_idx_q + 1'b1;
    end
  end

  // R3
  bank_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> (age_q[issue_bank] >= AGE_W'(BUSY)));

  // R6
  elem_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid_o |-> (elem_idx_o == exp_idx_q));

  // R7
  done_with_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> elem_valid_o);

  // R1
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R1
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  // R6
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !elem_valid_o);
endmodule

bind strided_load_engine strided_load_engine_chk #(
  .NB(NB), .BUSY(BUSY), .MAX_LEN(MAX_LEN)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sn),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .elem_valid_o (elem_valid_o),
  .elem_idx_o   (elem_idx_o),
  .done_o       (done_o),
  .issue_fire   (issue_fire),
  .issue_bank   (issue_bank)
);

// File: tb/strided_load_engine_bench.sv
module strided_load_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  base_i = '0;
  logic [7:0]  stride_i = '0;
  logic [5:0]  len_m1_i = '0;
  logic        busy_o, elem_valid_o, done_o;
  logic [5:0]  elem_idx_o;
  logic [15:0] elem_data_o;
  logic [15:0] done_cycles_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  strided_load_engine u_strided_load_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .stride_i(stride_i), .len_m1_i(len_m1_i), .busy_o(busy_o),
    .elem_valid_o(elem_valid_o), .elem_idx_o(elem_idx_o),
    .elem_data_o(elem_data_o), .done_o(done_o), .done_cycles_o(done_cycles_o)
  );

  localparam int NT = 10;
  localparam logic [7:0] T_BASE   [NT] = '{8'd0, 8'd5,  8'd0, 8'd10, 8'd7, 8'd200, 8'd1, 8'd250, 8'd0,  8'd100};
  localparam logic [7:0] T_STRIDE [NT] = '{8'd1, 8'd32, 8'd2, 8'd4,  8'd3, 8'd6,   8'd5, 8'd1,   8'd12, 8'd255};
  localparam logic [5:0] T_LENM1  [NT] = '{6'd63, 6'd63, 6'd63, 6'd63, 6'd19, 6'd8, 6'd0, 6'd9, 6'd6, 6'd15};
  localparam int         T_CYC    [NT] = '{76, 391, 106, 200, 32, 25, 13, 22, 31, 28};

  function automatic logic [15:0] word_at(input logic [7:0] a);
    return {a ^ 8'h5A, a};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [7:0] b, input logic [7:0] s, input logic [5:0] lm1,
                         input int exp_cyc, input int gap_exp, input int inject_at);
    int n = int'(lm1) + 1;
    int got = 0;
    int t0;
    int last_t = 0;
    bit fin = 0;
    @(negedge clk);
    start_i = 1'b1; base_i = b; stride_i = s; len_m1_i = lm1;
    t0 = cyc;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R1 busy after start", int'(busy_o), 1);
    for (int w = 0; w < 2000 && !fin; w++) begin
      if (inject_at > 0 && w == inject_at) begin
        start_i = 1'b1; base_i = 8'd77; stride_i = 8'd1; len_m1_i = 6'd0;
      end else begin
        start_i = 1'b0;
      end
      if (elem_valid_o) begin
        logic [7:0] a;
        a = b + 8'(got) * s;
        check(int'(elem_idx_o) == got, "R6 element index", int'(elem_idx_o), got);
        check(elem_data_o == word_at(a), "R2 element word", int'(elem_data_o), int'(word_at(a)));
        if (got == 0)
          check(cyc - t0 == 13, "R5 first element delay", cyc - t0, 13);
        else if (gap_exp > 0)
          check(cyc - last_t == gap_exp, "R8 R3 same-bank spacing", cyc - last_t, gap_exp);
        last_t = cyc;
        got++;
        if (done_o) begin
          check(int'(done_cycles_o) == exp_cyc, "R7 R4 done cycle count", int'(done_cycles_o), exp_cyc);
          check(cyc - t0 == exp_cyc, "R4 last element timing", cyc - t0, exp_cyc);
          check(got == n, "R6 element total", got, n);
          fin = 1;
        end
      end else begin
        check(done_o == 1'b0, "R7 done without element", int'(done_o), 0);
      end
      if (!fin) @(negedge clk);
    end
    start_i = 1'b0;
    check(fin, "R7 load completion", int'(fin), 1);
    @(negedge clk);
    check(busy_o == 1'b0, "R1 idle after done", int'(busy_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: idle state under reset
    check(busy_o == 1'b0 && elem_valid_o == 1'b0 && done_o == 1'b0,
          "R10 outputs in reset", int'({busy_o, elem_valid_o, done_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy_o == 1'b0, "R10 idle after release", int'(busy_o), 0);

    for (int i = 0; i < NT; i++)
      run_vec(T_BASE[i], T_STRIDE[i], T_LENM1[i], T_CYC[i], 0, 0);

    // R8: zero stride repeats one word, six cycles apart
    run_vec(8'd3, 8'd0, 6'd4, 37, 6, 0);

    // R9: a second start during a load is ignored
    run_vec(8'd9, 8'd0, 6'd63, 391, 6, 20);

    // R10: reset in mid-load abandons it
    @(negedge clk);
    start_i = 1'b1; base_i = 8'd0; stride_i = 8'd1; len_m1_i = 6'd63;
    @(negedge clk);
    start_i = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(busy_o == 1'b0, "R10 busy cleared by reset", int'(busy_o), 0);
    check(elem_valid_o == 1'b0, "R10 stream cleared by reset", int'(elem_valid_o), 0);
    check(done_o == 1'b0, "R10 done cleared by reset", int'(done_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy_o == 1'b0 && elem_valid_o == 1'b0, "R10 quiet after release",
          int'({busy_o, elem_valid_o}), 0);
    run_vec(8'd40, 8'd3, 6'd7, 20, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule